// File: doc/BRIEF.md
# Interrupt Cause Register Bank with Per-Bit Clear Mode

This block holds the latched interrupt causes of one interrupt group together with their mask. Hardware event pulses on a parallel input latch cause bits; software reaches the bank through a single-port register interface. Each cause bit can be set to clear in one of two ways, chosen by a per-bit clear-mode register: by a read of the cause register, or by writing a one to it. The mask is never written directly. Software changes it through a set alias and a clear alias, and reads it back through a separate view.

A masked-cause view returns the causes that are not masked. A single group-pending output is high whenever any unmasked cause bit is set. Higher-level interrupt aggregation is built around this signal.

Register word addresses (`req_addr`): 0 cause, 1 cause-set alias, 2 mask-set alias, 3 mask-clear alias, 4 mask view, 5 masked-cause view, 6 clear-mode. Read data comes back on `rd_data` with `rd_valid` one cycle after the request.

Top module: `intr_cause_bank`

## Requirements
- R1: After reset the cause register reads 0, the mask view reads all ones, the clear-mode register reads 0 and `group_pending` is low.
- R2: A one on any bit of `hw_event` in a cycle sets that cause bit from the next cycle on.
- R3: A write to address 1 sets the cause bits at the positions where the written data is one and leaves the other cause bits unchanged.
- R4: A write to address 0 clears each cause bit whose data bit is one and whose clear-mode bit is 0. Cause bits whose clear-mode bit is 1 are not changed by such a write.
- R5: A read of address 0 returns the cause value held before the read. It then clears every set cause bit whose clear-mode bit is 1 and leaves the bits whose clear-mode bit is 0 set.
- R6: Clear modes can be mixed bit by bit. With clear-mode 0xF7FF_FFFF, bit 27 survives a cause read while the other bits are cleared by it.
- R7: A write to address 2 sets the mask bits at the written one positions. Other mask bits keep their values.
- R8: A write to address 3 clears the mask bits at the written one positions, which unmasks those sources. Other mask bits keep their values.
- R9: A read of address 4 returns the current mask, and `rd_valid` is high in the cycle after every read request.
- R10: A read of address 5 returns the cause value ANDed with the inverted mask.
- R11: `group_pending` is high exactly when some cause bit is set and its mask bit is 0.
- R12: When a hardware event and a clear hit the same cause bit in the same cycle, the bit stays set. This holds for a write-one clear and for a clear caused by a read.
- R13: Address 6 is read/write and holds the clear-mode register: a bit value of 1 means clear-on-read and 0 means write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | WIDTH | Write data |
| hw_event | input | WIDTH | Hardware event pulses, one per cause bit |
| rd_data | output | WIDTH | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| group_pending | output | 1 | Any unmasked cause bit set |

## Verification
The bench builds the bank with its default parameters: WIDTH of 32 and the combinational pending variant. This places a bit at position 27 and at the top bit 31, which is needed to reproduce the mixed clear-mode pattern of R6. The combinational variant lets `group_pending` be checked in the same cycle as the register state that drives it. The event-versus-clear race is driven for both clear paths by applying `hw_event` in the same cycle as the write or read. Mask aliases are then checked through the mask view and the masked-cause view.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CAUSE  = 3'd0,
      RA_SET    = 3'd1,
      RA_MSET   = 3'd2,
      RA_MCLR   = 3'd3,
      RA_MVIEW  = 3'd4,
      RA_MASKED = 3'd5,
      RA_MODE   = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/intr_cause_bit.sv
module intr_cause_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic set_i,
   input  logic w1c_i,
   input  logic rdclr_i,
   input  logic cor_mode_i,
   output logic q_o
);
   logic clr;

   always_comb clr = (w1c_i & ~cor_mode_i) | (rdclr_i & cor_mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q_o <= 1'b0;
      else if (event_i || set_i) q_o <= 1'b1;
      else if (clr)              q_o <= 1'b0;
   end

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> q_o); // R2
   AST_SWSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o); // R3
   AST_COR_IGNORES_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (cor_mode_i && w1c_i && !rdclr_i) |=> (q_o == $past(q_o) || q_o)); // R4
   AST_W1C_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cor_mode_i && rdclr_i && !w1c_i && q_o) |=> q_o); // R5
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_o <= '1;
      else if (set_we) mask_o <= mask_o | wdata;
      else if (clr_we) mask_o <= mask_o & ~wdata;
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask_o & $past(wdata)) == $past(wdata))); // R7
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((mask_o & $past(wdata)) == '0)); // R8
endmodule

// File: rtl/intr_rd_mux.sv
module intr_rd_mux
   import intr_cause_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  cause,
   input  logic [WIDTH-1:0]  mask,
   input  logic [WIDTH-1:0]  mode,
   output logic [WIDTH-1:0]  rd_data,
   output logic              rd_valid
);
   logic [WIDTH-1:0] sel;

   always_comb begin
      unique case (reg_addr_e'(addr))
         RA_CAUSE:  sel = cause;
         RA_MVIEW:  sel = mask;
         RA_MASKED: sel = cause & ~mask;
         RA_MODE:   sel = mode;
         default:   sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= sel;
      end
   end

   AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid); // R9
endmodule

// File: rtl/intr_cause_bank.sv
module intr_cause_bank
   import intr_cause_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit PENDING_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WIDTH-1:0]  req_wdata,
   input  logic [WIDTH-1:0]  hw_event,
   output logic [WIDTH-1:0]  rd_data,
   output logic              rd_valid,
   output logic              group_pending
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("intr_cause_bank: WIDTH must lie in 1..64");
   end

   logic             wr_req, rd_req;
   logic             wr_cause, wr_set, wr_mset, wr_mclr, wr_mode, rd_cause;
   logic [WIDTH-1:0] cause_q, mask_q, mode_q, unmasked;

   always_comb begin
      wr_req   = req_valid &  req_write;
      rd_req   = req_valid & ~req_write;
      wr_cause = wr_req & (req_addr == RA_CAUSE);
      wr_set   = wr_req & (req_addr == RA_SET);
      wr_mset  = wr_req & (req_addr == RA_MSET);
      wr_mclr  = wr_req & (req_addr == RA_MCLR);
      wr_mode  = wr_req & (req_addr == RA_MODE);
      rd_cause = rd_req & (req_addr == RA_CAUSE);
      unmasked = cause_q & ~mask_q;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      intr_cause_bit u_bit (
         .clk        (clk),
         .rst_n      (rst_n),
         .event_i    (hw_event[i]),
         .set_i      (wr_set & req_wdata[i]),
         .w1c_i      (wr_cause & req_wdata[i]),
         .rdclr_i    (rd_cause),
         .cor_mode_i (mode_q[i]),
         .q_o        (cause_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= req_wdata;
   end

   intr_mask_reg #(.WIDTH(WIDTH)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_mset),
      .clr_we (wr_mclr),
      .wdata  (req_wdata),
      .mask_o (mask_q)
   );

   intr_rd_mux #(.WIDTH(WIDTH)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .addr     (req_addr),
      .cause    (cause_q),
      .mask     (mask_q),
      .mode     (mode_q),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   if (PENDING_REG) begin : g_pend_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) group_pending <= 1'b0;
         else        group_pending <= |unmasked;
      end
   end else begin : g_pend_comb
      always_comb group_pending = |unmasked;
   end

   AST_EVENT_BEATS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cause && ((hw_event & req_wdata) != '0))
      |=> ((cause_q & $past(hw_event & req_wdata)) == $past(hw_event & req_wdata))); // R12
   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (mode_q == $past(req_wdata))); // R13
endmodule

// File: tb/intr_cause_bank_bench.sv
module intr_cause_bank_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [2:0]   req_addr = '0;
   logic [W-1:0] req_wdata = '0;
   logic [W-1:0] hw_event = '0;
   logic [W-1:0] rd_data;
   logic         rd_valid;
   logic         group_pending;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } exp_item_t;

   exp_item_t sb[$];

   always #2.5 clk = ~clk;

   intr_cause_bank u_intr_cause_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .hw_event(hw_event),
      .rd_data(rd_data), .rd_valid(rd_valid), .group_pending(group_pending)
   );

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         n_tests++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read data: actual %h expected none", rd_data);
         end else begin
            exp_item_t it;
            it = sb.pop_front();
            if (rd_data !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] ev);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; hw_event = ev;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; hw_event = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input logic [W-1:0] ev,
                     input string tag);
      exp_item_t it;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; hw_event = ev;
      @(negedge clk);
      req_valid = 1'b0; hw_event = '0;
   endtask

   task automatic pulse(input logic [W-1:0] ev);
      @(negedge clk);
      hw_event = ev;
      @(negedge clk);
      hw_event = '0;
   endtask

   task automatic chk_pend(input logic exp, input string tag);
      n_tests++;
      if (group_pending !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, group_pending, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_pend(1'b0, "R1 pending at reset");
      rd(3'd0, 32'h0, '0, "R1 cause at reset");
      rd(3'd4, 32'hFFFF_FFFF, '0, "R1 mask at reset");
      rd(3'd6, 32'h0, '0, "R1 mode at reset");
      // R2 event sets, still masked
      pulse(32'h0000_0011);
      rd(3'd0, 32'h0000_0011, '0, "R2 event latch");
      chk_pend(1'b0, "R11 masked cause not pending");
      // R8/R9/R10/R11 unmask bit 0
      wr(3'd3, 32'h1, '0);
      rd(3'd4, 32'hFFFF_FFFE, '0, "R8 R9 mask clear alias");
      chk_pend(1'b1, "R11 unmasked cause pending");
      rd(3'd5, 32'h1, '0, "R10 masked-cause view");
      // R4 write one to clear
      wr(3'd0, 32'h10, '0);
      rd(3'd0, 32'h1, '0, "R4 w1c clears only written bit");
      chk_pend(1'b1, "R11 still pending");
      wr(3'd0, 32'h1, '0);
      rd(3'd0, 32'h0, '0, "R4 w1c clears bit 0");
      chk_pend(1'b0, "R11 pending drops");
      // R3 software set
      wr(3'd1, 32'h8000_0004, '0);
      rd(3'd0, 32'h8000_0004, '0, "R3 set alias");
      // R13 mode register
      wr(3'd6, 32'hF7FF_FFFF, '0);
      rd(3'd6, 32'hF7FF_FFFF, '0, "R13 mode readback");
      // R5/R6 clear on read, mixed modes
      pulse(32'h0800_0008);
      rd(3'd0, 32'h8800_000C, '0, "R5 read returns pre-clear value");
      rd(3'd0, 32'h0800_0000, '0, "R6 bit 27 survives read");
      wr(3'd1, 32'h2, '0);
      wr(3'd0, 32'h0800_0002, '0);
      rd(3'd0, 32'h2, '0, "R4 clear-on-read bit ignores w1c");
      rd(3'd0, 32'h0, '0, "R5 read cleared bit 1");
      // R7/R8 mask aliases
      wr(3'd2, 32'h1, '0);
      rd(3'd4, 32'hFFFF_FFFF, '0, "R7 mask set alias");
      wr(3'd3, 32'hF0, '0);
      rd(3'd4, 32'hFFFF_FF0F, '0, "R8 mask clear alias");
      wr(3'd2, 32'h30, '0);
      rd(3'd4, 32'hFFFF_FF3F, '0, "R7 partial set");
      // R12 event beats clear
      wr(3'd6, 32'h0, '0);
      wr(3'd1, 32'h20, '0);
      rd(3'd5, 32'h0, '0, "R10 masked bit hidden");
      chk_pend(1'b0, "R11 masked bit not pending");
      wr(3'd3, 32'h20, '0);
      chk_pend(1'b1, "R11 unmasked bit 5 pending");
      rd(3'd5, 32'h20, '0, "R10 bit 5 visible");
      wr(3'd0, 32'h20, 32'h20);
      rd(3'd0, 32'h20, '0, "R12 event beats w1c");
      wr(3'd6, 32'h20, '0);
      rd(3'd0, 32'h20, 32'h20, "R12 event beats read clear");
      rd(3'd0, 32'h20, '0, "R12 bit kept after racing read");
      rd(3'd0, 32'h0, '0, "R5 later read clears");
      chk_pend(1'b0, "R11 final not pending");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL R9 missing reads: actual %0d left expected 0", sb.size());
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule